// File: doc/BRIEF.md
# Serial-Loaded Wiper Position Register

This block is the digital control section of a 256-step digitally controlled resistor. A host writes a new wiper position over a three-wire, write-only serial port made of an active-low select, a serial clock and a serial data line. While select is low, every rising edge of the serial clock shifts one data bit into a shift register. When select returns high, the last eight bits received become the new wiper code.

The code drives the tap decoder of the resistor ladder. Code 0x00 places the wiper on the bottom end contact. Code 0xFF selects the top tap, which is one step below the upper end. The block can also present the code as a one-hot tap vector.

The serial pins are not used as clocks. A system clock, running at least four times faster than the serial clock, samples them through two-flop synchronizers and finds edges by comparing successive samples. The serial clock may run at up to 25 MHz. Select must stay high for at least 40 ns between frames.

Top module: `serial_wiper_ctl`

## Requirements
- R1: Bits are received most significant bit first: the first bit of an eight-bit frame lands in code bit 7 and the last in code bit 0.
- R2: A data bit is taken only on a rising edge of the serial clock while select is low; serial clock edges while select is high neither shift data nor count toward a frame.
- R3: The wiper code does not change while select is low; a new value is written only after select rises.
- R4: When a frame has more than eight rising clock edges, the earlier bits are discarded and the last eight bits received become the code.
- R5: Reset sets the wiper code to midscale, 0x80, and holds `code_updated` low.
- R6: A frame with fewer than eight rising clock edges before select rises is discarded, and the previous code is kept.
- R7: `code_updated` is high for exactly one system clock cycle after each commit, in the cycle in which the new code first appears, and it never pulses for a discarded frame.
- R8: `tap_onehot` has exactly one bit set, and that bit's index equals the wiper code.
- R9: A falling edge of select restarts the bit count, so the bits of two short frames never add up to a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_pin | input | 1 | Serial select, active low |
| sclk_pin | input | 1 | Serial clock; data is taken on its rising edge |
| sdata_pin | input | 1 | Serial data, most significant bit first |
| wiper_code | output | 8 | Committed wiper position, 0x00 at the bottom end, 0xFF at the top tap |
| tap_onehot | output | 256 | One-hot form of the wiper code |
| code_updated | output | 1 | One-cycle pulse when a new code is committed |

## Verification
The bench loads every one of the 256 codes. A design with reversed bit order, or a misplaced bit, would show a wrong code or a wrong one-hot index. It sends frames of eleven bits: a design that kept the first eight bits, or whose counter wrapped past eight, would commit the wrong value or nothing at all. It sends frames of five and six bits, some of them after clock edges applied while select was high. A design that committed a partial frame, counted edges while deselected, or carried its count across frames would change the code and pulse `code_updated` when it should not. It also reads the code while select is still low after eight bits: a design that wrote the code early would already show the new value.

// File: rtl/serial_wiper_ctl.sv
module serial_wiper_ctl #(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit ONEHOT_EN   = 1'b1,
  localparam int TAPS  = 1 << CODE_W,
  localparam int CNT_W = $clog2(CODE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_pin,
  input  logic              sclk_pin,
  input  logic              sdata_pin,
  output logic [CODE_W-1:0] wiper_code,
  output logic [TAPS-1:0]   tap_onehot,
  output logic              code_updated
);

  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(CODE_W);

  logic [SYNC_STAGES-1:0] sclk_sy, sdat_sy, sel_sy;
  logic sclk_q, sel_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_sy <= '0;
      sdat_sy <= '0;
      sel_sy  <= '1;
      sclk_q  <= 1'b0;
      sel_q   <= 1'b1;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk_pin};
      sdat_sy <= {sdat_sy[SYNC_STAGES-2:0], sdata_pin};
      sel_sy  <= {sel_sy[SYNC_STAGES-2:0],  sel_n_pin};
      sclk_q  <= sclk_sy[SYNC_STAGES-1];
      sel_q   <= sel_sy[SYNC_STAGES-1];
    end

  logic sclk_s, sdat_s, sel_s;
  assign sclk_s = sclk_sy[SYNC_STAGES-1];
  assign sdat_s = sdat_sy[SYNC_STAGES-1];
  assign sel_s  = sel_sy[SYNC_STAGES-1];

  logic sclk_rise, sel_fall, sel_rise, full, commit;
  assign sclk_rise = sclk_s & ~sclk_q;
  assign sel_fall  = ~sel_s & sel_q;
  assign sel_rise  = sel_s & ~sel_q;

  logic [CODE_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;

  assign full   = (bit_cnt == FULL_CNT);
  assign commit = sel_rise & full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (sel_fall) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (!sel_s && sclk_rise) begin
      shreg   <= {shreg[CODE_W-2:0], sdat_s};
      bit_cnt <= full ? bit_cnt : bit_cnt + CNT_W'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wiper_code   <= MID_CODE;
      code_updated <= 1'b0;
    end else begin
      code_updated <= commit;
      if (commit) wiper_code <= shreg;
    end

  generate
    if (ONEHOT_EN) begin : g_onehot
      assign tap_onehot = TAPS'(1) << wiper_code;
    end else begin : g_no_onehot
      assign tap_onehot = '0;
    end
  endgenerate

endmodule

// File: rtl/serial_wiper_ctl_chk.sv
module serial_wiper_ctl_chk #(
  parameter int CODE_W    = 8,
  parameter bit ONEHOT_EN = 1'b1,
  localparam int TAPS  = 1 << CODE_W,
  localparam int CNT_W = $clog2(CODE_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_s,
  input logic              sel_q,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [CODE_W-1:0] wiper_code,
  input logic [TAPS-1:0]   tap_onehot,
  input logic              code_updated
);

  a_r4_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(CODE_W));

  a_r3_hold_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |=> $stable(wiper_code));

  a_r6_short_frame_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s && !sel_q && bit_cnt < CNT_W'(CODE_W)) |=> $stable(wiper_code) && !code_updated);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    code_updated |=> !code_updated);

  a_r7_change_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper_code != $past(wiper_code)) |-> code_updated);

  generate
    if (ONEHOT_EN) begin : g_oh
      a_r8_single_tap: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_onehot) == 1);
    end
  endgenerate

endmodule

bind serial_wiper_ctl serial_wiper_ctl_chk #(.CODE_W(CODE_W), .ONEHOT_EN(ONEHOT_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .sel_q(sel_q), .bit_cnt(bit_cnt),
  .wiper_code(wiper_code), .tap_onehot(tap_onehot), .code_updated(code_updated)
);

// File: tb/test_serial_wiper_ctl.sv
`timescale 1ns/1ps
module test_serial_wiper_ctl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b0, sdat = 1'b0;
  logic [7:0]   code;
  logic [255:0] onehot;
  logic         upd;

  int checks = 0, fails = 0, pulses = 0;
  logic upd_prev = 1'b0;

  always #10 clk = ~clk;

  serial_wiper_ctl i_serial_wiper_ctl (
    .clk(clk), .rst_n(rst_n), .sel_n_pin(sel_n), .sclk_pin(sclk), .sdata_pin(sdat),
    .wiper_code(code), .tap_onehot(onehot), .code_updated(upd)
  );

  always @(negedge clk) begin
    if (rst_n && upd) pulses++;
    if (rst_n && upd && upd_prev) begin
      checks++; fails++;
      $display("FAIL R7 code_updated wide: actual 1 expected 0");
    end
    upd_prev = upd;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = bits[i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
  endtask

  task automatic send(input logic [15:0] bits, input int n);
    sel_n = 1'b0;
    wait_clk(4);
    shift_bits(bits, n);
    sel_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog expired: actual running expected done");
    finish_up();
  end

  initial begin
    logic [7:0] held;
    int p0;
    wait_clk(5);
    chk(code == 8'h80, "R5 reset code", code, 8'h80);
    chk(upd == 1'b0, "R5 reset strobe", upd, 0);
    rst_n = 1'b1;
    wait_clk(3);
    chk(onehot == (256'd1 << 128), "R8 reset onehot", onehot[128], 1);

    // R1 R8 R7: exhaustive sweep of all codes
    for (int v = 0; v < 256; v++) begin
      logic [7:0] e;
      e = 8'(v ^ 8'h5A);
      p0 = pulses;
      send({8'h00, e}, 8);
      chk(code == e, "R1 code", code, e);
      chk(onehot == (256'd1 << e), "R8 onehot", onehot == (256'd1 << e), 1);
      chk(pulses == p0 + 1, "R7 one pulse per commit", pulses - p0, 1);
    end

    // R3: code stays put while select low
    send(16'h0033, 8);
    sel_n = 1'b0;
    wait_clk(4);
    shift_bits(16'h00C4, 8);
    wait_clk(8);
    chk(code == 8'h33, "R3 hold while selected", code, 8'h33);
    sel_n = 1'b1;
    wait_clk(10);
    chk(code == 8'hC4, "R3 commit on rise", code, 8'hC4);

    // R4: overlong frames keep the last eight bits
    send(16'h05A7, 11);
    chk(code == 8'hA7, "R4 overlong 11 bits", code, 8'hA7);
    send(16'hFF01, 16);
    chk(code == 8'h01, "R4 overlong 16 bits", code, 8'h01);

    // R6: short frames discarded
    held = code; p0 = pulses;
    send(16'h001F, 5);
    chk(code == held, "R6 short frame", code, held);
    chk(pulses == p0, "R7 no pulse on discard", pulses - p0, 0);

    // R9: two short frames do not add up
    send(16'h0002, 3);
    chk(code == held, "R9 count restarts", code, held);

    // R2: edges while deselected are ignored
    shift_bits(16'h000F, 4);
    send(16'h0015, 6);
    chk(code == held, "R2 high-select edges ignored", code, held);
    shift_bits(16'h00AA, 8);
    send(16'h0096, 8);
    chk(code == 8'h96, "R2 frame after stray edges", code, 8'h96);

    // R5: reset mid-operation returns to midscale
    rst_n = 1'b0;
    wait_clk(2);
    chk(code == 8'h80, "R5 reset again", code, 8'h80);
    rst_n = 1'b1;
    wait_clk(4);
    send(16'h00FF, 8);
    chk(code == 8'hFF, "R1 top tap", code, 8'hFF);

    finish_up();
  end

endmodule